// File: doc/BRIEF.md
# Hazard-Resolving Pre-Reduction Unit

This block sits in front of one accumulator bank whose adder takes LAT cycles to produce a result. It takes a stream of (row index, product value) pairs, up to one per cycle, and makes sure the accumulator never receives two updates to the same row fewer than LAT cycles apart. It does this by merging values with the same index, not by stalling the input. Without merging, the accumulator could read a row before the previous add to that row has been written back.

The window is a LAT-deep shift register of (valid, index, partial sum) slots. An accepted pair whose index matches an occupied slot among the first LAT-1 positions is added into that slot. Otherwise it starts a new slot at the head. The last slot is about to leave the window and is never merged into. The tail slot is the output. The whole window advances on every cycle in which the output is free or is consumed. A flush input stops intake so that pending slots drain at the end of a matrix pass, and an empty flag reports when no slot is occupied. Values are two's-complement and wrap modulo 2^32. A pipelined integer adder stands in for the floating-point one.

Top module: `hrt_prereduce`

## Requirements
- R1: After reset, out_valid is 0, empty is 1 and in_ready is 1 while flush is 0.
- R2: Whenever out_ready is 1 and flush is 0, in_ready is 1, so one pair per cycle is accepted with no internal stall.
- R3: For every index, the sum modulo 2^32 of all emitted values equals the sum of all accepted values.
- R4: Two output handshakes (out_valid and out_ready both 1) carrying the same out_idx are at least LAT clock edges apart.
- R5: With out_ready held at 1, a pair accepted at clock edge e that merges with nothing is emitted alone at edge e+LAT.
- R6: Pairs with the same index accepted on consecutive edges within the window produce a single output holding their sum, emitted LAT edges after the first of them.
- R7: While out_valid is 1 and out_ready is 0, out_idx and out_val hold steady, in_ready is 0 and no pending value is lost.
- R8: While flush is 1, in_ready is 0. With out_ready at 1, empty is 1 within LAT edges of flush rising.
- R9: A pair accepted LAT-1 edges after an earlier pair with the same index is merged into it. A pair accepted exactly LAT edges after the earlier one starts a new entry, emitted LAT edges after the first emission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input pair is offered |
| in_ready | output | 1 | The block accepts the offered pair this cycle |
| in_idx | input | 16 | Row index of the offered pair |
| in_val | input | 32 | Product value of the offered pair, two's-complement |
| flush | input | 1 | Stop intake so the window drains |
| out_valid | output | 1 | A reduced pair is offered downstream |
| out_ready | input | 1 | Downstream takes the offered pair |
| out_idx | output | 16 | Row index of the reduced pair |
| out_val | output | 32 | Combined sum for that index |
| empty | output | 1 | No slot of the window is occupied |

## Verification
Several events can fall on the same clock edge. The tail slot can leave the window while a new pair with the same index arrives, which must open a fresh slot rather than join the departing one. A merge into a middle slot can also coincide with an emission and with backpressure. Directed sequences place same-index pairs exactly LAT-1 and LAT edges apart and check the count, values and edges of the outputs. A long random stream over a handful of indices, with out_ready toggling, then makes these coincidences frequent. That stream is judged by per-index sum conservation and by the spacing between same-index emissions, measured in clock edges.

// File: rtl/hrt_pkg.sv
package hrt_pkg;
  parameter int unsigned IDX_W = 16;
  parameter int unsigned VAL_W = 32;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] sum;
  } slot_t;

  // Wrapping two's-complement addition used for every merge
  function automatic logic [VAL_W-1:0] hrt_fold(input logic [VAL_W-1:0] a,
                                                input logic [VAL_W-1:0] b);
    return a + b;
  endfunction

  // A slot with one more value folded into its partial sum
  function automatic slot_t hrt_absorb(input slot_t s, input logic [VAL_W-1:0] v);
    slot_t r;
    r     = s;
    r.sum = hrt_fold(s.sum, v);
    return r;
  endfunction
endpackage

// File: rtl/hrt_match.sv
module hrt_match
  import hrt_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  slot_t [LAT-2:0] cand,
  input  logic [IDX_W-1:0] idx,
  output logic [LAT-2:0]   hit
);
  // Compare the incoming index against every slot that may still absorb
  for (genvar i = 0; i < LAT - 1; i++) begin : g_cmp
    assign hit[i] = cand[i].valid && (cand[i].idx == idx);
  end
endmodule

// File: rtl/hrt_window.sv
module hrt_window
  import hrt_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  input  logic [VAL_W-1:0] take_val,
  input  logic [LAT-2:0]   hit,
  output slot_t [LAT-1:0]  win
);
  slot_t [LAT-1:0] nxt;
  logic            absorbed;

  assign absorbed = take && (|hit);

  // Head slot: a fresh entry only when the pair matched nothing
  assign nxt[0] = '{valid: take && !absorbed, idx: take_idx, sum: take_val};

  // Every other slot takes its predecessor, plus the new value on a match
  for (genvar i = 1; i < LAT; i++) begin : g_slot
    assign nxt[i] = (take && hit[i-1]) ? hrt_absorb(win[i-1], take_val) : win[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       win <= '0;
    else if (advance) win <= nxt;
  end
endmodule

// File: rtl/hrt_prereduce.sv
module hrt_prereduce
  import hrt_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [VAL_W-1:0] in_val,
  input  logic             flush,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_idx,
  output logic [VAL_W-1:0] out_val,
  output logic             empty
);
  slot_t [LAT-1:0] win;
  logic [LAT-2:0]  hit;
  logic [LAT-1:0]  occ;
  logic            advance;
  logic            accept;
  logic            emit;

  // The window moves as a whole whenever its tail is free or consumed
  assign advance   = !win[LAT-1].valid || out_ready;
  assign in_ready  = advance && !flush;
  assign accept    = in_valid && in_ready;
  assign emit      = out_valid && out_ready;

  assign out_valid = win[LAT-1].valid;
  assign out_idx   = win[LAT-1].idx;
  assign out_val   = win[LAT-1].sum;

  for (genvar i = 0; i < LAT; i++) begin : g_occ
    assign occ[i] = win[i].valid;
  end
  assign empty = (occ == '0);

  hrt_match #(.LAT(LAT)) u_match (
    .cand (win[LAT-2:0]),
    .idx  (in_idx),
    .hit  (hit)
  );

  hrt_window #(.LAT(LAT)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .take     (accept),
    .take_idx (in_idx),
    .take_val (in_val),
    .hit      (hit),
    .win      (win)
  );
endmodule

// File: rtl/hrt_prereduce_chk.sv
module hrt_prereduce_chk
  import hrt_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             flush,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_idx,
  input logic [VAL_W-1:0] out_val,
  input logic             empty,
  input logic [LAT-2:0]   hit,
  input logic             emit
);
  // Emissions of the previous LAT-1 cycles
  logic [LAT-2:0]            hv;
  logic [LAT-2:0][IDX_W-1:0] hi;
  logic                      too_close;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv <= '0;
      hi <= '0;
    end else begin
      for (int j = LAT - 2; j > 0; j--) begin
        hv[j] <= hv[j-1];
        hi[j] <= hi[j-1];
      end
      hv[0] <= emit;
      hi[0] <= out_idx;
    end
  end

  always_comb begin
    too_close = 1'b0;
    for (int j = 0; j < LAT - 1; j++)
      if (hv[j] && hi[j] == out_idx) too_close = 1'b1;
  end

  // R4
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> !too_close);

  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !flush) |-> in_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_val)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  // R6
  single_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R1
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !out_valid);
endmodule

bind hrt_prereduce hrt_prereduce_chk #(.LAT(LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .flush     (flush),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_idx   (out_idx),
  .out_val   (out_val),
  .empty     (empty),
  .hit       (hit),
  .emit      (emit)
);

// File: tb/tb_hrt_prereduce.sv
module tb_hrt_prereduce;
  localparam int LAT  = 4;
  localparam int NLOG = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_idx = '0;
  logic [31:0] in_val = '0;
  logic        flush = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_idx;
  logic [31:0] out_val;
  logic        empty;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [31:0] in_sum  [16];
  logic [31:0] out_sum [16];
  int          last_edge [16];
  bit          seen [16];

  int          lg_k    [NLOG];
  logic [31:0] lg_v    [NLOG];
  int          lg_e    [NLOG];
  int          n_out = 0;

  hrt_prereduce #(.LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_val(in_val), .flush(flush), .out_valid(out_valid),
    .out_ready(out_ready), .out_idx(out_idx), .out_val(out_val), .empty(empty)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] k2idx(input int k);
    return (k == 15) ? 16'hFFFF : 16'(k);
  endfunction

  function automatic int idx2k(input logic [15:0] i);
    return (i == 16'hFFFF) ? 15 : int'(i[3:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: samples after the negedge drive has settled, before the next edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (in_valid && in_ready)
        in_sum[idx2k(in_idx)] = in_sum[idx2k(in_idx)] + in_val;
      if (out_valid && out_ready) begin
        automatic int k = idx2k(out_idx);
        if (seen[k]) chk((cyc + 1 - last_edge[k]) >= LAT, "R4 spacing", cyc + 1 - last_edge[k], LAT);
        seen[k] = 1'b1;
        last_edge[k] = cyc + 1;
        out_sum[k] = out_sum[k] + out_val;
        if (n_out < NLOG) begin
          lg_k[n_out] = k;
          lg_v[n_out] = out_val;
          lg_e[n_out] = cyc + 1;
          n_out++;
        end
      end
      if (out_ready && !flush) chk(in_ready, "R2 full rate", in_ready, 1);
    end
  end

  task automatic drive(input bit v, input int k, input logic [31:0] val,
                       input bit ordy, input bit fl);
    @(negedge clk);
    in_valid  = v;
    in_idx    = k2idx(k);
    in_val    = val;
    out_ready = ordy;
    flush     = fl;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(1'b0, 0, 32'd0, 1'b1, 1'b0);
  endtask

  task automatic scan(input int mark, input int k, output int n,
                      output int v0, output int e0, output int v1, output int e1);
    n = 0; v0 = 0; e0 = 0; v1 = 0; e1 = 0;
    for (int j = mark; j < n_out; j++) begin
      if (lg_k[j] == k) begin
        if (n == 0) begin v0 = int'(lg_v[j]); e0 = lg_e[j]; end
        else if (n == 1) begin v1 = int'(lg_v[j]); e1 = lg_e[j]; end
        n++;
      end
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_test();
  end

  initial begin
    int mark, n, v0, e0, v1, e1, e, e2, dummy;
    bit sv_ok;
    for (int k = 0; k < 16; k++) begin
      in_sum[k] = '0; out_sum[k] = '0; seen[k] = 1'b0; last_edge[k] = 0;
    end
    dummy = $urandom(32'd24680);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R1
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

    // R5 lone pair
    mark = n_out;
    drive(1'b1, 3, 32'd100, 1'b1, 1'b0); e = cyc + 1;
    idle(LAT + 3);
    scan(mark, 3, n, v0, e0, v1, e1);
    chk(n == 1, "R5 count", n, 1);
    chk(v0 == 100, "R5 value", v0, 100);
    chk(e0 == e + LAT, "R5 edge", e0, e + LAT);

    // R6 consecutive same-index pairs
    mark = n_out;
    drive(1'b1, 5, 32'd1, 1'b1, 1'b0); e = cyc + 1;
    drive(1'b1, 5, 32'd2, 1'b1, 1'b0);
    drive(1'b1, 5, 32'd3, 1'b1, 1'b0);
    idle(LAT + 3);
    scan(mark, 5, n, v0, e0, v1, e1);
    chk(n == 1, "R6 count", n, 1);
    chk(v0 == 6, "R6 sum", v0, 6);
    chk(e0 == e + LAT, "R6 edge", e0, e + LAT);

    // R9 second pair LAT-1 edges later: merged
    mark = n_out;
    drive(1'b1, 7, 32'd10, 1'b1, 1'b0); e = cyc + 1;
    idle(LAT - 2);
    drive(1'b1, 7, 32'd20, 1'b1, 1'b0); e2 = cyc + 1;
    chk(e2 == e + LAT - 1, "R9 setup", e2, e + LAT - 1);
    idle(LAT + 3);
    scan(mark, 7, n, v0, e0, v1, e1);
    chk(n == 1, "R9 merged count", n, 1);
    chk(v0 == 30, "R9 merged sum", v0, 30);
    chk(e0 == e + LAT, "R9 merged edge", e0, e + LAT);

    // R9 second pair exactly LAT edges later: separate
    mark = n_out;
    drive(1'b1, 9, 32'd1, 1'b1, 1'b0); e = cyc + 1;
    idle(LAT - 1);
    drive(1'b1, 9, 32'd2, 1'b1, 1'b0);
    idle(2 * LAT + 3);
    scan(mark, 9, n, v0, e0, v1, e1);
    chk(n == 2, "R9 split count", n, 2);
    chk(v0 == 1 && e0 == e + LAT, "R9 first", e0, e + LAT);
    chk(v1 == 2 && e1 == e + 2 * LAT, "R9 second", e1, e + 2 * LAT);

    // R7 backpressure
    mark = n_out;
    drive(1'b1, 11, 32'd55, 1'b0, 1'b0);
    repeat (LAT + 3) drive(1'b0, 0, 32'd0, 1'b0, 1'b0);
    #3;
    chk(out_valid == 1'b1, "R7 held valid", out_valid, 1);
    chk(out_idx == 16'd11, "R7 held idx", out_idx, 11);
    chk(out_val == 32'd55, "R7 held val", out_val, 55);
    chk(in_ready == 1'b0, "R7 intake blocked", in_ready, 0);
    drive(1'b1, 11, 32'd5, 1'b0, 1'b0);
    #3;
    sv_ok = (out_val == 32'd55) && (in_ready == 1'b0);
    chk(sv_ok, "R7 offered pair ignored", out_val, 55);
    idle(LAT + 3);
    scan(mark, 11, n, v0, e0, v1, e1);
    chk(n == 1 && v0 == 55, "R7 no loss", v0, 55);

    // Random collision-rich stream with toggling backpressure (R3, R4)
    for (int t = 0; t < 4000; t++) begin
      automatic int k = ($urandom % 2 == 0) ? int'($urandom % 4) : int'($urandom % 16);
      drive($urandom_range(0, 9) < 8, k, $urandom, $urandom_range(0, 9) < 7, 1'b0);
    end

    // R8 flush
    drive(1'b1, 2, 32'd77, 1'b1, 1'b1);
    #3;
    chk(in_ready == 1'b0, "R8 flush blocks intake", in_ready, 0);
    repeat (LAT) drive(1'b1, 2, 32'd77, 1'b1, 1'b1);
    #3;
    chk(empty == 1'b1, "R8 drained", empty, 1);
    chk(out_valid == 1'b0, "R8 no output", out_valid, 0);
    idle(3);

    // R3 per-index conservation
    for (int k = 0; k < 16; k++)
      chk(in_sum[k] == out_sum[k], "R3 conservation", out_sum[k], in_sum[k]);

    finish_test();
  end
endmodule